// File: doc/BRIEF.md
# Motor Driver Fault Manager

This block sits between the protection detectors of a brushed DC motor H-bridge and the bridge itself. It takes the overcurrent, overtemperature, overvoltage, stall and current-regulation-active indications. Each protective fault class can either hold the bridge off until software clears it, or let the bridge come back on its own. The block combines those states with the software output-enable bit to form the bridge enable; when that enable is low, every FET is in Hi-Z.

The block also drives the active-low fault pin. The pin goes low for any held or pending fault. It can also go low for a detected stall and for cycle-by-cycle current regulation, and each of these two reports can be switched on or off. A write strobe for the clear-faults bit raises a readable bit for exactly one cycle. Held faults are cleared at the end of that cycle. If a new fault is sampled in that same cycle, the new fault takes priority and stays held.

All configuration bits come in as plain levels from a register interface outside the block.

Top module: `motor_fault_mgr`

## Requirements
- R1: `bridge_en` is 0 whenever `cfg_out_en` is 0. With no fault held or pending, `bridge_en` equals `cfg_out_en` in the same cycle.
- R2: With `cfg_ocp_retry` = 0, an `ocp_evt` sampled at a clock edge drives `bridge_en` and `fault_n` to 0 after that edge. They stay 0 until a clear takes effect.
- R3: With `cfg_ocp_retry` = 1, the bridge stays disabled (and `fault_n` low) for exactly RETRY_CYC cycles after the last edge that sampled `ocp_evt` high. A new `ocp_evt` during that window restarts the count.
- R4: With `cfg_tsd_retry` = 0, an `tsd_evt` holds the bridge off and `fault_n` low until a clear, whatever `tsd_cool` does.
- R5: With `cfg_tsd_retry` = 1, an overtemperature fault stays pending until an edge samples `tsd_cool` = 1 with `tsd_evt` = 0. The bridge is re-enabled after that edge.
- R6: A one-cycle `clr_wr` sets `clr_bit` to 1 for exactly one cycle, after which it returns to 0 by itself. Held faults are cleared at the edge that ends that cycle. A pending auto-retry fault is not affected by the clear.
- R7: If a fault event is sampled on the same edge as an active clear, the fault stays held.
- R8: `ovp_evt` is ignored while `cfg_ovp_en` = 0. When enabled, it disables the bridge and pulls `fault_n` low from the edge after it is sampled. It releases on the first edge that samples it low.
- R9: When `cfg_stall_en` = 1 and `cfg_stall_rep` = 1, `stall_evt` pulls `fault_n` low after the edge that samples it. If either bit is 0, a stall has no effect on `fault_n`. A stall never changes `bridge_en`.
- R10: With `cfg_cbc_rep` = 1 and `cfg_reg_mode` = 2'b01 (cycle-by-cycle), `creg_act` pulls `fault_n` low after the edge that samples it. For any other mode value, or with `cfg_cbc_rep` = 0, it has no effect.
- R11: After reset no fault is held or pending: `fault_n` = 1 and `clr_bit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_out_en | input | 1 | Software enable for the bridge outputs |
| cfg_ovp_en | input | 1 | Overvoltage response enable |
| cfg_stall_en | input | 1 | Stall event enable |
| cfg_ocp_retry | input | 1 | Overcurrent: 0 hold off, 1 timed retry |
| cfg_tsd_retry | input | 1 | Overtemperature: 0 hold off, 1 resume when cool |
| cfg_stall_rep | input | 1 | Report stall on the fault pin |
| cfg_cbc_rep | input | 1 | Report cycle-by-cycle regulation on the fault pin |
| cfg_reg_mode | input | 2 | Current regulation mode, 2'b01 is cycle-by-cycle |
| clr_wr | input | 1 | Write strobe of 1 to the clear-faults bit |
| ocp_evt | input | 1 | Overcurrent detected |
| tsd_evt | input | 1 | Overtemperature detected |
| tsd_cool | input | 1 | Temperature below threshold minus hysteresis |
| ovp_evt | input | 1 | Overvoltage detected |
| stall_evt | input | 1 | Stall detected |
| creg_act | input | 1 | Bridge is in internal current regulation |
| clr_bit | output | 1 | Readback of the self-clearing clear bit |
| bridge_en | output | 1 | Bridge drive enable, 0 puts all FETs in Hi-Z |
| fault_n | output | 1 | Active-low fault pin |

## Verification
The hardest case to reach is a new fault landing on the one edge where the clear bit is high. From the ports, the only way there is to time the event to the cycle right after the clear strobe. The stimulus holds a latched overcurrent, writes the clear, and raises `ocp_evt` on the next cycle. It then checks that the fault is still held after the clear bit has dropped. The retry window is measured one cycle at a time, using a small RETRY_CYC and restarting it mid-window.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
  localparam int unsigned NCH = 3;
  localparam int unsigned CH_OCP = 0;
  localparam int unsigned CH_TSD = 1;
  localparam int unsigned CH_OVP = 2;
  localparam logic [1:0] REGMODE_CBC = 2'b01;

  typedef struct packed {
    logic latched;
    logic pending;
  } chan_st_t;
endpackage

// File: rtl/mfm_retry_timer.sv
module mfm_retry_timer #(
  parameter int unsigned RETRY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic done
);
  localparam int unsigned CW = $clog2(RETRY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RETRY_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm)                cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !arm) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/mfm_fault_chan.sv
module mfm_fault_chan
  import mfm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     evt,
  input  logic     retry_mode,
  input  logic     release_ok,
  input  logic     clr,
  output chan_st_t st
);
  chan_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (evt) begin
      if (retry_mode) st_d.pending = 1'b1;
      else            st_d.latched = 1'b1;
    end else begin
      if (clr)                      st_d.latched = 1'b0;
      if (st_q.pending && release_ok) st_d.pending = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.latched && !clr) |=> st_q.latched);
  // R7
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !retry_mode) |=> st_q.latched);
endmodule

// File: rtl/mfm_report.sv
module mfm_report
  import mfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_fault,
  input  logic       stall_evt,
  input  logic       stall_en,
  input  logic       stall_rep,
  input  logic       creg_act,
  input  logic       cbc_rep,
  input  logic [1:0] reg_mode,
  output logic       fault_n
);
  logic stall_q, stall_d, cbc_q, cbc_d;

  always_comb begin
    stall_d = stall_evt & stall_en & stall_rep;
    cbc_d   = creg_act & cbc_rep & (reg_mode == REGMODE_CBC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      cbc_q   <= 1'b0;
    end else begin
      stall_q <= stall_d;
      cbc_q   <= cbc_d;
    end
  end

  assign fault_n = ~(any_fault | stall_q | cbc_q);

  // R9
  stall_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_evt && stall_en && stall_rep) |=> !fault_n);
  // R10
  cbc_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (creg_act && cbc_rep && reg_mode == REGMODE_CBC) |=> !fault_n);
endmodule

// File: rtl/motor_fault_mgr.sv
module motor_fault_mgr
  import mfm_pkg::*;
#(
  parameter int unsigned RETRY_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_out_en,
  input  logic       cfg_ovp_en,
  input  logic       cfg_stall_en,
  input  logic       cfg_ocp_retry,
  input  logic       cfg_tsd_retry,
  input  logic       cfg_stall_rep,
  input  logic       cfg_cbc_rep,
  input  logic [1:0] cfg_reg_mode,
  input  logic       clr_wr,
  input  logic       ocp_evt,
  input  logic       tsd_evt,
  input  logic       tsd_cool,
  input  logic       ovp_evt,
  input  logic       stall_evt,
  input  logic       creg_act,
  output logic       clr_bit,
  output logic       bridge_en,
  output logic       fault_n
);
  logic           clr_q, clr_d;
  logic           tmr_done;
  logic [NCH-1:0] evt_v, mode_v, rel_v;
  chan_st_t       st_v [NCH];
  logic           any_fault;

  always_comb clr_d = clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr_d;
  end
  assign clr_bit = clr_q;

  mfm_retry_timer #(.RETRY_CYC(RETRY_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (ocp_evt),
    .done (tmr_done)
  );

  always_comb begin
    evt_v  = '0;
    mode_v = '0;
    rel_v  = '0;
    evt_v[CH_OCP]  = ocp_evt;
    mode_v[CH_OCP] = cfg_ocp_retry;
    rel_v[CH_OCP]  = tmr_done;
    evt_v[CH_TSD]  = tsd_evt;
    mode_v[CH_TSD] = cfg_tsd_retry;
    rel_v[CH_TSD]  = tsd_cool;
    evt_v[CH_OVP]  = ovp_evt & cfg_ovp_en;
    mode_v[CH_OVP] = 1'b1;
    rel_v[CH_OVP]  = 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    mfm_fault_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt_v[g]),
      .retry_mode(mode_v[g]),
      .release_ok(rel_v[g]),
      .clr       (clr_q),
      .st        (st_v[g])
    );
  end

  always_comb begin
    any_fault = 1'b0;
    for (int i = 0; i < NCH; i++) any_fault = any_fault | st_v[i].latched | st_v[i].pending;
  end

  assign bridge_en = cfg_out_en & ~any_fault;

  mfm_report u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_fault(any_fault),
    .stall_evt(stall_evt),
    .stall_en (cfg_stall_en),
    .stall_rep(cfg_stall_rep),
    .creg_act (creg_act),
    .cbc_rep  (cfg_cbc_rep),
    .reg_mode (cfg_reg_mode),
    .fault_n  (fault_n)
  );

  // R6
  clr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bit && !clr_wr) |=> !clr_bit);
  // R3
  ocp_blocks_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_evt |=> (!bridge_en && !fault_n));
  // R1
  out_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_out_en |-> !bridge_en);
endmodule

// File: tb/motor_fault_mgr_tb_top.sv
module motor_fault_mgr_tb_top;
  localparam int RC = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_out_en, cfg_ovp_en, cfg_stall_en, cfg_ocp_retry, cfg_tsd_retry;
  logic cfg_stall_rep, cfg_cbc_rep;
  logic [1:0] cfg_reg_mode;
  logic clr_wr, ocp_evt, tsd_evt, tsd_cool, ovp_evt, stall_evt, creg_act;
  logic clr_bit, bridge_en, fault_n;

  always #2 clk = ~clk;

  motor_fault_mgr #(.RETRY_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_out_en(cfg_out_en), .cfg_ovp_en(cfg_ovp_en),
    .cfg_stall_en(cfg_stall_en), .cfg_ocp_retry(cfg_ocp_retry),
    .cfg_tsd_retry(cfg_tsd_retry), .cfg_stall_rep(cfg_stall_rep),
    .cfg_cbc_rep(cfg_cbc_rep), .cfg_reg_mode(cfg_reg_mode), .clr_wr(clr_wr),
    .ocp_evt(ocp_evt), .tsd_evt(tsd_evt), .tsd_cool(tsd_cool), .ovp_evt(ovp_evt),
    .stall_evt(stall_evt), .creg_act(creg_act), .clr_bit(clr_bit),
    .bridge_en(bridge_en), .fault_n(fault_n)
  );

  typedef struct {
    logic  fn;
    logic  be;
    logic  cb;
    string tag;
  } exp_t;

  exp_t expq[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      n_cmp++;
      if (fault_n !== e.fn || bridge_en !== e.be || clr_bit !== e.cb) begin
        n_bad++;
        $display("FAIL %s: got fault_n=%b bridge_en=%b clr_bit=%b, expected %b %b %b",
                 e.tag, fault_n, bridge_en, clr_bit, e.fn, e.be, e.cb);
      end
    end
  end

  // driver: one clock edge, then queue the expected outputs after it
  task automatic step(input logic efn, input logic ebe, input logic ecb, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.fn = efn; e.be = ebe; e.cb = ecb; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_out_en = 0; cfg_ovp_en = 1; cfg_stall_en = 1; cfg_ocp_retry = 1;
    cfg_tsd_retry = 1; cfg_stall_rep = 1; cfg_cbc_rep = 1; cfg_reg_mode = 2'b00;
    clr_wr = 0; ocp_evt = 0; tsd_evt = 0; tsd_cool = 0; ovp_evt = 0;
    stall_evt = 0; creg_act = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    step(1, 0, 0, "R11 reset state");
    cfg_out_en = 1;
    step(1, 1, 0, "R1 enable follows");

    // R2: latched overcurrent
    cfg_ocp_retry = 0; ocp_evt = 1;
    step(0, 0, 0, "R2 ocp latches");
    ocp_evt = 0;
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R2 ocp held");
    clr_wr = 1;
    step(0, 0, 1, "R6 clear bit set");
    clr_wr = 0;
    step(1, 1, 0, "R6 clear releases latch");

    // R3: timed retry
    cfg_ocp_retry = 1; ocp_evt = 1;
    step(0, 0, 0, "R3 ocp pending");
    ocp_evt = 0;
    step(0, 0, 0, "R3 window");
    step(0, 0, 0, "R3 window");
    ocp_evt = 1;
    step(0, 0, 0, "R3 restart");
    ocp_evt = 0;
    clr_wr = 1;
    step(0, 0, 1, "R6 clear during retry");
    clr_wr = 0;
    for (int i = 0; i < RC - 2; i++) step(0, 0, 0, "R6 pending survives clear");
    step(1, 1, 0, "R3 retry expires");

    // R4: latched thermal
    cfg_tsd_retry = 0; tsd_evt = 1;
    step(0, 0, 0, "R4 tsd latches");
    tsd_evt = 0; tsd_cool = 1;
    step(0, 0, 0, "R4 cool ignored");
    step(0, 0, 0, "R4 cool ignored");
    clr_wr = 1;
    step(0, 0, 1, "R4 clear");
    clr_wr = 0;
    step(1, 1, 0, "R4 released");

    // R5: thermal auto-resume
    cfg_tsd_retry = 1; tsd_evt = 1; tsd_cool = 0;
    step(0, 0, 0, "R5 tsd pending");
    tsd_evt = 0;
    step(0, 0, 0, "R5 still hot");
    step(0, 0, 0, "R5 still hot");
    tsd_cool = 1;
    step(1, 1, 0, "R5 cool resumes");
    tsd_cool = 0;

    // R7: new event on the clear edge
    cfg_ocp_retry = 0; ocp_evt = 1;
    step(0, 0, 0, "R7 latch");
    ocp_evt = 0; clr_wr = 1;
    step(0, 0, 1, "R7 clear armed");
    clr_wr = 0; ocp_evt = 1;
    step(0, 0, 0, "R7 event wins");
    ocp_evt = 0;
    step(0, 0, 0, "R7 still latched");
    clr_wr = 1;
    step(0, 0, 1, "R7 clear again");
    clr_wr = 0;
    step(1, 1, 0, "R7 released");
    cfg_ocp_retry = 1;

    // R8: overvoltage gating
    cfg_ovp_en = 0; ovp_evt = 1;
    step(1, 1, 0, "R8 ovp ignored");
    cfg_ovp_en = 1;
    step(0, 0, 0, "R8 ovp active");
    ovp_evt = 0;
    step(1, 1, 0, "R8 ovp released");

    // R9: stall reporting
    stall_evt = 1;
    step(0, 1, 0, "R9 stall reported");
    cfg_stall_rep = 0;
    step(1, 1, 0, "R9 report off");
    cfg_stall_rep = 1; cfg_stall_en = 0;
    step(1, 1, 0, "R9 stall disabled");
    stall_evt = 0; cfg_stall_en = 1;

    // R10: regulation reporting
    creg_act = 1; cfg_reg_mode = 2'b00;
    step(1, 1, 0, "R10 other mode");
    cfg_reg_mode = 2'b01;
    step(0, 1, 0, "R10 cbc reported");
    cfg_cbc_rep = 0;
    step(1, 1, 0, "R10 report off");
    creg_act = 0; cfg_cbc_rep = 1;

    // R1: enable low overrides
    cfg_out_en = 0;
    step(1, 0, 0, "R1 enable low");

    @(posedge clk);
    @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule